// File: doc/BRIEF.md
# PHY Register Access Controller

This block lets software read and write the internal registers of a physical-layer device through a single link-side control word. Software writes the word to set a register address, an outgoing data byte and a read or write request bit. The block then presents the request on a valid/ready handshake toward the PHY interface. Once the PHY side accepts it, the block clears the request bit by itself.

Register transfers coming back from the PHY arrive as single-cycle responses carrying a 4-bit address and an 8-bit data byte. The block stores them in the readback word, sets a done flag and pulses a register-received event. Unsolicited transfers from the PHY are handled the same way as answers to reads. The serial line encoding between link and PHY is not part of this block.

Top module: `phyRegAccess`

## Requirements
- R1: After reset the readback word `ctrlRead` is all zero, `phyReqValid` is low and `regRcvdEvent` is low.
- R2: A control write with bit 14 set and no request pending starts a register write. From the next cycle, `phyReqValid` is high, `phyReqWrite` is high, `phyReqAddr` equals written bits 11:8, `phyReqData` equals written bits 7:0, and readback bit 14 reads 1.
- R3: A control write with bit 15 set and bit 14 clear, with no request pending, starts a register read. From the next cycle, `phyReqValid` is high, `phyReqWrite` is low, `phyReqAddr` equals written bits 11:8, and readback bit 15 reads 1.
- R4: When bits 14 and 15 are both set in one control write, only the write is issued. Readback bit 15 stays 0 and `phyReqWrite` is high.
- R5: While `phyReqValid` is high and `phyReqReady` is low, the request and its address and data hold steady. In the cycle after `phyReqValid` and `phyReqReady` are both high, `phyReqValid` is low and readback bits 15 and 14 are 0.
- R6: A control write that arrives while a request is pending is ignored entirely. Readback bits 15:0 and the outstanding request are unchanged.
- R7: A control write that starts a request clears the done flag, readback bit 31, in the next cycle.
- R8: A cycle with `phyRspValid` high loads `phyRspAddr` into readback bits 27:24 and `phyRspData` into bits 23:16, and sets bit 31, all visible in the next cycle. This holds whether or not a read was requested.
- R9: `regRcvdEvent` is high for exactly the one cycle after each cycle in which `phyRspValid` is high, and low otherwise.
- R10: When a response arrives in the same cycle as a control write that starts a request, the done flag ends up set and the new request is still issued.
- R11: A control write with neither bit 14 nor bit 15 set, and no request pending, updates only readback bits 11:0. It leaves the done flag, the received fields and `phyReqValid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Software write strobe for the control word |
| cfgWrData | input | 32 | Control word written by software |
| ctrlRead | output | 32 | Readback of the control word |
| phyReqValid | output | 1 | Request to the PHY interface is pending |
| phyReqReady | input | 1 | PHY interface accepts the pending request |
| phyReqWrite | output | 1 | 1 = register write, 0 = register read |
| phyReqAddr | output | 4 | Target PHY register address |
| phyReqData | output | 8 | Byte to write |
| phyRspValid | input | 1 | A register transfer arrives from the PHY |
| phyRspAddr | input | 4 | Address of the arriving register |
| phyRspData | input | 8 | Contents of the arriving register |
| regRcvdEvent | output | 1 | One-cycle register-received event |

## Verification
The bench targets several corner cases, each of which a faulty design would get visibly wrong.
- A write that lands while a request is still pending: a design that accepted it would change the address or turn a write into a read in flight.
- Setting both request bits in one write: a design that let the read win would issue `phyReqWrite` low.
- A response that coincides with a new request: a design that let the clear win would leave the done flag at 0 after data actually arrived.
- Unsolicited responses and writes that carry no request bit: if either were mishandled, the received fields or the done flag would change when they should not.

// File: rtl/phyRegPkg.sv
package phyRegPkg;
  parameter int WORD_W = 32;
  parameter int ADDR_W = 4;
  parameter int DATA_W = 8;

  localparam int DONE_BIT = 31;
  localparam int RXA_LSB  = 24;
  localparam int RXD_LSB  = 16;
  localparam int RD_BIT   = 15;
  localparam int WR_BIT   = 14;
  localparam int TXA_LSB  = 8;
  localparam int TXD_LSB  = 0;

  typedef struct packed {
    logic loadFields;
    logic newReq;
    logic capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/phyRegCtrl.sv
module phyRegCtrl
  import phyRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        reqWrBit,
  input  logic        reqRdBit,
  input  logic        phyReqReady,
  input  logic        phyRspValid,
  output logic        rdPend,
  output logic        wrPend,
  output ctrlStrobe_t strobe
);
  logic busy, accept, wantWr, wantRd, issue;

  assign busy   = rdPend | wrPend;
  assign accept = cfgWrEn & ~busy;
  // write has priority; a read requested alongside it is dropped
  assign wantWr = accept & reqWrBit;
  assign wantRd = accept & reqRdBit & ~reqWrBit;
  assign issue  = busy & phyReqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend <= 1'b0;
      wrPend <= 1'b0;
    end else if (issue) begin
      rdPend <= 1'b0;
      wrPend <= 1'b0;
    end else begin
      if (wantWr) wrPend <= 1'b1;
      if (wantRd) rdPend <= 1'b1;
    end
  end

  always_comb begin
    strobe.loadFields = accept;
    strobe.newReq     = wantWr | wantRd;
    strobe.capture    = phyRspValid;
  end
endmodule

// File: rtl/phyRegDatapath.sv
module phyRegDatapath
  import phyRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] txAddrIn,
  input  logic [DATA_W-1:0] txDataIn,
  input  logic [ADDR_W-1:0] rxAddrIn,
  input  logic [DATA_W-1:0] rxDataIn,
  output logic [ADDR_W-1:0] txAddr,
  output logic [DATA_W-1:0] txData,
  output logic [ADDR_W-1:0] rxAddr,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              rcvdPulse
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txAddr    <= '0;
      txData    <= '0;
      rxAddr    <= '0;
      rxData    <= '0;
      doneFlag  <= 1'b0;
      rcvdPulse <= 1'b0;
    end else begin
      if (strobe.loadFields) begin
        txAddr <= txAddrIn;
        txData <= txDataIn;
      end
      if (strobe.capture) begin
        rxAddr <= rxAddrIn;
        rxData <= rxDataIn;
      end
      // arrival outranks the clear from a new request
      if (strobe.capture)     doneFlag <= 1'b1;
      else if (strobe.newReq) doneFlag <= 1'b0;
      rcvdPulse <= strobe.capture;
    end
  end
endmodule

// File: rtl/phyRegAccess.sv
module phyRegAccess
  import phyRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic [WORD_W-1:0] ctrlRead,
  output logic              phyReqValid,
  input  logic              phyReqReady,
  output logic              phyReqWrite,
  output logic [ADDR_W-1:0] phyReqAddr,
  output logic [DATA_W-1:0] phyReqData,
  input  logic              phyRspValid,
  input  logic [ADDR_W-1:0] phyRspAddr,
  input  logic [DATA_W-1:0] phyRspData,
  output logic              regRcvdEvent
);
  ctrlStrobe_t       strobe;
  logic              rdPend, wrPend, doneFlag;
  logic [ADDR_W-1:0] txAddr, rxAddr;
  logic [DATA_W-1:0] txData, rxData;
  logic              unusedBits;

  assign unusedBits = ^{cfgWrData[WORD_W-1:RXD_LSB], cfgWrData[WR_BIT-1:TXA_LSB+ADDR_W]};

  phyRegCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn),
    .reqWrBit(cfgWrData[WR_BIT]), .reqRdBit(cfgWrData[RD_BIT]),
    .phyReqReady(phyReqReady), .phyRspValid(phyRspValid),
    .rdPend(rdPend), .wrPend(wrPend), .strobe(strobe)
  );

  phyRegDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txAddrIn(cfgWrData[TXA_LSB +: ADDR_W]),
    .txDataIn(cfgWrData[TXD_LSB +: DATA_W]),
    .rxAddrIn(phyRspAddr), .rxDataIn(phyRspData),
    .txAddr(txAddr), .txData(txData),
    .rxAddr(rxAddr), .rxData(rxData),
    .doneFlag(doneFlag), .rcvdPulse(regRcvdEvent)
  );

  always_comb begin
    ctrlRead                    = '0;
    ctrlRead[DONE_BIT]          = doneFlag;
    ctrlRead[RXA_LSB +: ADDR_W] = rxAddr;
    ctrlRead[RXD_LSB +: DATA_W] = rxData;
    ctrlRead[RD_BIT]            = rdPend;
    ctrlRead[WR_BIT]            = wrPend;
    ctrlRead[TXA_LSB +: ADDR_W] = txAddr;
    ctrlRead[TXD_LSB +: DATA_W] = txData;
  end

  assign phyReqValid = rdPend | wrPend;
  assign phyReqWrite = wrPend;
  assign phyReqAddr  = txAddr;
  assign phyReqData  = txData;
endmodule

// File: rtl/phyRegChecker.sv
module phyRegChecker
  import phyRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [WORD_W-1:0] cfgWrData,
  input logic [WORD_W-1:0] ctrlRead,
  input logic              phyReqValid,
  input logic              phyReqReady,
  input logic              phyReqWrite,
  input logic [ADDR_W-1:0] phyReqAddr,
  input logic [DATA_W-1:0] phyReqData,
  input logic              phyRspValid,
  input logic [ADDR_W-1:0] phyRspAddr,
  input logic [DATA_W-1:0] phyRspData,
  input logic              regRcvdEvent
);
  // R4
  both_bits_never_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlRead[RD_BIT] && ctrlRead[WR_BIT]));

  // R4
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && !phyReqValid && cfgWrData[WR_BIT] |=> phyReqValid && phyReqWrite);

  // R5
  hold_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    phyReqValid && !phyReqReady |=> phyReqValid && $stable(phyReqWrite)
      && $stable(phyReqAddr) && $stable(phyReqData));

  // R5
  drop_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    phyReqValid && phyReqReady |=> !phyReqValid);

  // R6
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    phyReqValid && !phyReqReady && cfgWrEn |=> $stable(ctrlRead[15:0]));

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    phyRspValid |=> ctrlRead[DONE_BIT]
      && ctrlRead[RXA_LSB +: ADDR_W] == $past(phyRspAddr)
      && ctrlRead[RXD_LSB +: DATA_W] == $past(phyRspData));

  // R9
  event_follows_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    phyRspValid |=> regRcvdEvent);

  // R9
  event_only_after_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !phyRspValid |=> !regRcvdEvent);
endmodule

bind phyRegAccess phyRegChecker i_chk (.*);

// File: tb/test_phyRegAccess.sv
module test_phyRegAccess;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] ctrlRead;
  logic        phyReqValid, phyReqWrite, regRcvdEvent;
  logic        phyReqReady = 1'b0;
  logic [3:0]  phyReqAddr;
  logic [7:0]  phyReqData;
  logic        phyRspValid = 1'b0;
  logic [3:0]  phyRspAddr = '0;
  logic [7:0]  phyRspData = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  phyRegAccess i_phyRegAccess (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic swWrite(input logic [31:0] w);
    cfgWrEn = 1'b1; cfgWrData = w;
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic handshake();
    phyReqReady = 1'b1;
    @(posedge clk); @(negedge clk);
    phyReqReady = 1'b0;
  endtask

  task automatic respond(input logic [3:0] a, input logic [7:0] d);
    phyRspValid = 1'b1; phyRspAddr = a; phyRspData = d;
    @(posedge clk); @(negedge clk);
    phyRspValid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctrlRead", ctrlRead, 32'h0);
    check("R1 valid", {31'b0, phyReqValid}, 32'h0);
    check("R1 event", {31'b0, regRcvdEvent}, 32'h0);
  endtask

  task automatic t_write();
    swWrite(32'h0000_4A5C);
    check("R2 valid", {31'b0, phyReqValid}, 32'h1);
    check("R2 write", {31'b0, phyReqWrite}, 32'h1);
    check("R2 addr", {28'b0, phyReqAddr}, 32'hA);
    check("R2 data", {24'b0, phyReqData}, 32'h5C);
    check("R2 readback", ctrlRead & 32'h0000_FFFF, 32'h0000_4A5C);
    repeat (3) @(negedge clk);
    check("R5 held", {phyReqValid, phyReqWrite, 18'b0, phyReqAddr, phyReqData}, {2'b11, 18'b0, 12'hA5C});
    handshake();
    check("R5 dropped", {31'b0, phyReqValid}, 32'h0);
    check("R5 bits clear", ctrlRead & 32'h0000_C000, 32'h0);
  endtask

  task automatic t_read();
    swWrite(32'h0000_8300);
    check("R3 valid", {31'b0, phyReqValid}, 32'h1);
    check("R3 write low", {31'b0, phyReqWrite}, 32'h0);
    check("R3 addr", {28'b0, phyReqAddr}, 32'h3);
    check("R3 readback", ctrlRead & 32'h0000_C000, 32'h0000_8000);
    handshake();
  endtask

  task automatic t_both();
    swWrite(32'h0000_C712);
    check("R4 write issued", {31'b0, phyReqWrite}, 32'h1);
    check("R4 bits", ctrlRead & 32'h0000_C000, 32'h0000_4000);
    handshake();
  endtask

  task automatic t_busy();
    swWrite(32'h0000_4281);
    swWrite(32'h0000_8F00);
    check("R6 fields", ctrlRead & 32'h0000_FFFF, 32'h0000_4281);
    check("R6 still write", {31'b0, phyReqWrite}, 32'h1);
    handshake();
  endtask

  task automatic t_resp();
    respond(4'h5, 8'hA7);
    check("R8 done", {31'b0, ctrlRead[31]}, 32'h1);
    check("R8 rx addr", {28'b0, ctrlRead[27:24]}, 32'h5);
    check("R8 rx data", {24'b0, ctrlRead[23:16]}, 32'hA7);
    check("R9 event high", {31'b0, regRcvdEvent}, 32'h1);
    @(negedge clk);
    check("R9 event low", {31'b0, regRcvdEvent}, 32'h0);
  endtask

  task automatic t_clearDone();
    swWrite(32'h0000_8100);
    check("R7 done cleared", {31'b0, ctrlRead[31]}, 32'h0);
    handshake();
  endtask

  task automatic t_fieldsOnly();
    respond(4'h9, 8'h3C);
    swWrite(32'h0000_0B66);
    check("R11 low fields", ctrlRead & 32'h0000_FFFF, 32'h0000_0B66);
    check("R11 upper kept", ctrlRead & 32'hFFFF_0000, 32'h893C_0000);
    check("R11 no request", {31'b0, phyReqValid}, 32'h0);
  endtask

  task automatic t_collide();
    swWrite(32'h0000_8200);
    handshake();
    check("R7 done clear before", {31'b0, ctrlRead[31]}, 32'h0);
    cfgWrEn = 1'b1; cfgWrData = 32'h0000_4411;
    phyRspValid = 1'b1; phyRspAddr = 4'hE; phyRspData = 8'h01;
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0; phyRspValid = 1'b0;
    check("R10 done set", {31'b0, ctrlRead[31]}, 32'h1);
    check("R10 request issued", {phyReqValid, phyReqWrite}, 2'b11);
    check("R10 event", {31'b0, regRcvdEvent}, 32'h1);
    handshake();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_both();
    t_busy();
    t_resp();
    t_clearDone();
    t_fieldsOnly();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule